// File: doc/BRIEF.md
# Frame-Size-Scaled Word FIFO

This block is a single-clock word queue with 32 physical storage slots whose usable depth is chosen at run time. A configuration write latches a large-queue enable and the current frame width; from those the block picks an effective depth of 32, 16, 8 or 4 words, so that narrow frames get a deep queue and wide frames a shallow one. Two instances are meant to sit inside a serial-peripheral master, one holding words waiting to be shifted out and one holding words shifted in.

The queue offers a push port, a show-ahead pop port, a flush, an occupancy count and four level flags: empty, one-before-empty, full and one-before-full. A push that finds the queue at its effective depth is dropped without any trace, and a pop of an empty queue reads zero and does nothing. Lowering the depth below the words already held keeps those words; the queue simply refuses new ones until it has drained below the new limit.

Top module: `spf_fifo`

## Requirements
- R1: After reset the count is 0, empty is 1, full, full_nxt and empty_nxt are 0, pop_data is 0 and the effective depth is 4.
- R2: A configuration write (cfg_wr=1) with cfg_big=0 sets the effective depth to 4 regardless of cfg_frame.
- R3: A configuration write with cfg_big=1 sets the depth to 32 when cfg_frame is at most 8, to 16 when it is 9 to 16, to 8 when it is 17 to 32, and to 4 when it is above 32.
- R4: A push while the count is at or above the effective depth is dropped: the count and the stored words are unchanged.
- R5: full is 1 exactly when the count is at or above the depth, full_nxt is 1 exactly when the count equals depth minus one, empty is 1 exactly when the count is 0 and empty_nxt is 1 exactly when the count is 1; all follow the count one clock after the push or pop that moves it.
- R6: Words leave in the order they were accepted; pop_data shows the oldest word combinationally, and a pop advances to the next one at the clock edge.
- R7: A pop of an empty queue leaves the count at 0 and pop_data reads 0.
- R8: flush=1 empties the queue at the next edge (count 0, empty 1, full 0) and overrides a push or pop in the same cycle.
- R9: The depth changes only on a configuration write; cfg_big and cfg_frame have no effect at other times.
- R10: When a configuration write lowers the depth below the count, the stored words are kept in order, full reads 1, and pushes are refused until the count has fallen below the new depth.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe; latches cfg_big and cfg_frame |
| cfg_big | input | 1 | Large-queue enable sampled on cfg_wr |
| cfg_frame | input | 6 | Frame width in bits sampled on cfg_wr |
| flush | input | 1 | Discard all stored words |
| push | input | 1 | Push request |
| push_data | input | 32 | Word to push |
| pop | input | 1 | Pop request |
| pop_data | output | 32 | Oldest stored word, 0 when empty |
| count | output | 6 | Number of stored words |
| full | output | 1 | Count at or above effective depth |
| empty | output | 1 | Count is zero |
| full_nxt | output | 1 | Count equals depth minus one |
| empty_nxt | output | 1 | Count equals one |

## Verification
Count and every flag are registered outcomes of the request in the previous cycle, so each is due one rising edge after the push, pop, flush or configuration write; pop_data is the exception and is due in the same cycle as the state it reflects. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge, reading pop_data before the pop it belongs to is applied. Depth is never read directly: each tier is measured by pushing past the limit and observing where the count stops.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // Depth tiers: FULL = all physical slots, each step halves, MIN = fixed floor
  typedef enum logic [1:0] {
    TIER_FULL    = 2'd0,
    TIER_HALF    = 2'd1,
    TIER_QUARTER = 2'd2,
    TIER_MIN     = 2'd3
  } tier_e;

  // Pick a tier from the big enable and frame width; base is the widest
  // frame served by the full tier, each further tier doubles it.
  function automatic tier_e tier_of(input logic big, input int unsigned frame,
                                    input int unsigned base);
    tier_e t;
    if (!big)                t = TIER_MIN;
    else if (frame <= base)     t = TIER_FULL;
    else if (frame <= 2*base)   t = TIER_HALF;
    else if (frame <= 4*base)   t = TIER_QUARTER;
    else                        t = TIER_MIN;
    return t;
  endfunction

endpackage

// File: rtl/spf_depth_sel.sv
module spf_depth_sel
  import spf_pkg::*;
#(
  parameter int unsigned PHYS_DEPTH = 32,
  parameter int unsigned MIN_DEPTH  = 4,
  parameter int unsigned BASE_FRAME = 8,
  parameter int unsigned FRAME_W    = 6,
  localparam int unsigned CNT_W     = $clog2(PHYS_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_big,
  input  logic [FRAME_W-1:0] cfg_frame,
  output logic [CNT_W-1:0]   depth
);

  tier_e tier_q, tier_d;

  always_comb begin
    tier_d = tier_q;
    if (cfg_wr) tier_d = tier_of(cfg_big, int'(cfg_frame), BASE_FRAME);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tier_q <= TIER_MIN;
    else if (cfg_wr) tier_q <= tier_d;
  end

  always_comb begin
    unique case (tier_q)
      TIER_FULL:    depth = CNT_W'(PHYS_DEPTH);
      TIER_HALF:    depth = CNT_W'(PHYS_DEPTH / 2);
      TIER_QUARTER: depth = CNT_W'(PHYS_DEPTH / 4);
      default:      depth = CNT_W'(MIN_DEPTH);
    endcase
  end

  AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(depth)) else $error("depth moved without cfg write"); // R9

  AST_DEPTH_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(depth) == 1) else $error("depth not a power of two"); // R3

endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl #(
  parameter int unsigned PHYS_DEPTH = 32,
  localparam int unsigned PTR_W     = $clog2(PHYS_DEPTH),
  localparam int unsigned CNT_W     = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [CNT_W-1:0] depth,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);

  logic [PTR_W-1:0] wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] count_d;
  logic             take_push, take_pop, upd;

  // Push admitted only below the effective depth; pop only when data exists
  assign take_push = push && !flush && (count < depth);
  assign take_pop  = pop  && !flush && (count != '0);
  assign wr_en     = take_push;
  assign upd       = flush || take_push || take_pop;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (take_push) wr_ptr_d = wr_ptr + PTR_W'(1);
      if (take_pop)  rd_ptr_d = rd_ptr + PTR_W'(1);
      if (take_push && !take_pop)      count_d = count + CNT_W'(1);
      else if (take_pop && !take_push) count_d = count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (upd) begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(PHYS_DEPTH)) else $error("count above physical size"); // R4

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && count >= depth) |=> $stable(count))
    else $error("push into full queue changed count"); // R4

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && count == '0) |=> (count == '0))
    else $error("pop of empty queue changed count"); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)) else $error("flush left words behind"); // R8

  AST_PUSH_POP_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush && count != '0 && count < depth) |=> $stable(count))
    else $error("simultaneous push/pop moved count"); // R11

endmodule

// File: rtl/spf_store.sv
module spf_store #(
  parameter int unsigned PHYS_DEPTH = 32,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned PTR_W     = $clog2(PHYS_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot [PHYS_DEPTH];

  for (genvar i = 0; i < PHYS_DEPTH; i++) begin : g_slot
    logic ce;
    assign ce = wr_en && (wr_ptr == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot[i] <= '0;
      else if (ce) slot[i] <= wr_data;
    end
  end

  assign rd_data = slot[rd_ptr];

endmodule

// File: rtl/spf_fifo.sv
module spf_fifo #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PHYS_DEPTH = 32,
  parameter int unsigned MIN_DEPTH  = 4,
  parameter int unsigned BASE_FRAME = 8,
  parameter int unsigned FRAME_W    = 6,
  localparam int unsigned PTR_W     = $clog2(PHYS_DEPTH),
  localparam int unsigned CNT_W     = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_big,
  input  logic [FRAME_W-1:0] cfg_frame,
  input  logic               flush,
  input  logic               push,
  input  logic [DATA_W-1:0]  push_data,
  input  logic               pop,
  output logic [DATA_W-1:0]  pop_data,
  output logic [CNT_W-1:0]   count,
  output logic               full,
  output logic               empty,
  output logic               full_nxt,
  output logic               empty_nxt
);

  logic [CNT_W-1:0]  depth;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] head;

  spf_depth_sel #(
    .PHYS_DEPTH (PHYS_DEPTH),
    .MIN_DEPTH  (MIN_DEPTH),
    .BASE_FRAME (BASE_FRAME),
    .FRAME_W    (FRAME_W)
  ) u_depth (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_big   (cfg_big),
    .cfg_frame (cfg_frame),
    .depth     (depth)
  );

  spf_ctrl #(.PHYS_DEPTH(PHYS_DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .flush  (flush),
    .depth  (depth),
    .wr_en  (wr_en),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .count  (count)
  );

  spf_store #(.PHYS_DEPTH(PHYS_DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (push_data),
    .rd_ptr  (rd_ptr),
    .rd_data (head)
  );

  // Level flags follow the registered count against the latched depth
  assign empty     = (count == '0);
  assign empty_nxt = (count == CNT_W'(1));
  assign full      = (count >= depth);
  assign full_nxt  = (count == depth - CNT_W'(1));
  assign pop_data  = empty ? '0 : head;

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (pop_data == '0)) else $error("empty queue shows data"); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full) && !(full && full_nxt)) else $error("flag clash"); // R5

endmodule

// File: tb/spf_fifo_tb.sv
module spf_fifo_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_big;
  logic [5:0]  cfg_frame;
  logic        flush, push, pop;
  logic [31:0] push_data, pop_data;
  logic [5:0]  count;
  logic        full, empty, full_nxt, empty_nxt;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  spf_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_big(cfg_big),
    .cfg_frame(cfg_frame), .flush(flush), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .count(count), .full(full), .empty(empty),
    .full_nxt(full_nxt), .empty_nxt(empty_nxt)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic big, input int frame);
    cfg_big = big; cfg_frame = 6'(frame); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push1(input logic [31:0] d);
    push = 1'b1; push_data = d;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic pop1(output logic [31:0] d);
    d = pop_data;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 full_nxt", full_nxt, 0);
    chk("R1 empty_nxt", empty_nxt, 0);
    chk("R1 pop_data", pop_data, 0);
    for (int i = 0; i < 6; i++) push1(32'h100 + 32'(i));
    chk("R1 reset depth 4", count, 4);
    do_flush();
  endtask

  task automatic t_small();
    logic [31:0] d;
    cfg(1'b0, 8);
    push1(32'hA0);
    chk("R5 empty_nxt at 1", empty_nxt, 1);
    chk("R5 empty clear", empty, 0);
    push1(32'hA1); push1(32'hA2);
    chk("R5 full_nxt at 3", full_nxt, 1);
    chk("R5 full at 3", full, 0);
    push1(32'hA3);
    chk("R2 full at 4", full, 1);
    chk("R5 full_nxt clear", full_nxt, 0);
    push1(32'hEE);
    chk("R4 dropped count", count, 4);
    for (int i = 0; i < 4; i++) begin
      pop1(d);
      chk("R6 order", d, 32'hA0 + 32'(i));
    end
    chk("R4 drop left no word", count, 0);
    chk("R5 empty after drain", empty, 1);
  endtask

  task automatic t_tiers();
    int frames[7] = '{1, 8, 9, 16, 17, 32, 33};
    int depths[7] = '{32, 32, 16, 16, 8, 8, 4};
    for (int k = 0; k < 7; k++) begin
      cfg(1'b1, frames[k]);
      for (int i = 0; i < 40; i++) push1(32'(i));
      chk($sformatf("R3 depth frame %0d", frames[k]), count, depths[k]);
      chk("R3 full at depth", full, 1);
      do_flush();
    end
    cfg(1'b0, 1);
    for (int i = 0; i < 10; i++) push1(32'(i));
    chk("R2 big off depth", count, 4);
    do_flush();
  endtask

  task automatic t_no_cfg();
    cfg(1'b1, 8);
    cfg_big = 1'b0; cfg_frame = 6'd40;
    @(negedge clk);
    for (int i = 0; i < 12; i++) push1(32'(i));
    chk("R9 depth kept at 32", count, 12);
    chk("R9 not full", full, 0);
    do_flush();
  endtask

  task automatic t_pop_empty();
    logic [31:0] d;
    pop1(d);
    chk("R7 pop_data zero", d, 0);
    chk("R7 count stays", count, 0);
    chk("R7 empty stays", empty, 1);
  endtask

  task automatic t_flush();
    cfg(1'b0, 8);
    push1(32'h11); push1(32'h22);
    flush = 1'b1; push = 1'b1; pop = 1'b1; push_data = 32'h33;
    @(negedge clk);
    flush = 1'b0; push = 1'b0; pop = 1'b0;
    chk("R8 count", count, 0);
    chk("R8 empty", empty, 1);
    chk("R8 full", full, 0);
    chk("R8 pop_data", pop_data, 0);
  endtask

  task automatic t_shrink();
    logic [31:0] d;
    cfg(1'b1, 4);
    for (int i = 0; i < 10; i++) push1(32'h200 + 32'(i));
    cfg(1'b0, 4);
    chk("R10 words kept", count, 10);
    chk("R10 full", full, 1);
    push1(32'hBAD);
    chk("R10 push refused", count, 10);
    for (int i = 0; i < 7; i++) begin
      pop1(d);
      chk("R10 order", d, 32'h200 + 32'(i));
    end
    chk("R10 below depth", full, 0);
    push1(32'h300);
    chk("R10 push accepted", count, 4);
    for (int i = 7; i < 10; i++) begin
      pop1(d);
      chk("R10 tail order", d, 32'h200 + 32'(i));
    end
    pop1(d);
    chk("R10 new word", d, 32'h300);
  endtask

  task automatic t_both();
    logic [31:0] d;
    cfg(1'b0, 8);
    push1(32'h51); push1(32'h52);
    chk("R11 head before", pop_data, 32'h51);
    push = 1'b1; pop = 1'b1; push_data = 32'h53;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    chk("R11 count same", count, 2);
    pop1(d); chk("R11 next", d, 32'h52);
    pop1(d); chk("R11 pushed", d, 32'h53);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_big = 1'b0; cfg_frame = '0;
    flush = 1'b0; push = 1'b0; pop = 1'b0; push_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_tiers();
    t_no_cfg();
    t_pop_empty();
    t_flush();
    t_shrink();
    t_both();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule